// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters, and each counter stands for the past behaviour of the branches that map onto its entry. The fetch stage offers a program counter on a valid/ready lookup channel. One cycle after the lookup is accepted, the block returns the counter value it read. The prediction is taken when that counter is in its upper half.

The pipeline carries the returned counter value alongside the instruction. When the branch resolves, the pipeline presents the following on the update pins:
- the carried value,
- the real outcome,
- the table index,
- a flag that marks the instruction as a branch.

The block does not read the table again at update time. It steps the carried copy by one toward the outcome and writes the result into the entry. The lookup result channel has back-pressure. A result that is not accepted stays on the outputs unchanged. A new lookup is accepted only when the result register is empty or is being drained in the same cycle. The update pins carry no handshake and are sampled on every clock edge.

Top module: `bimodal_predictor`

## Requirements
- R1: A taken update writes the carried counter plus one, except that a carried value of 3 (all ones for a CTR_W of 2) is written back as 3.
- R2: A not-taken update writes the carried counter minus one, except that a carried value of 0 is written back as 0.
- R3: `pr_taken` is 1 exactly when the returned counter has its most significant bit set, which means a value of 2 or 3.
- R4: The entry index is `lk_pc[IDX_W+1:2]`. PC bits 1:0 and all PC bits above IDX_W+1 do not select the entry, so PCs that differ only in those bits read the same counter. With IDX_W of 14, this index is PC bits 15:2.
- R5: An update writes a value derived from `up_ctr` whatever the entry currently holds.
- R6: When `up_branch` is 0, the table is not written, whatever the other update pins show.
- R7: A synchronous active-high `rst` clears every counter to 0 and drops `pr_valid` at the next edge.
- R8: If a lookup is accepted in the same cycle as an update to the same entry, the lookup returns the value the entry held before that update. A later lookup sees the written value.
- R9: A lookup is accepted on an edge where `lk_valid` and `lk_ready` are both 1, and `lk_ready` equals `!pr_valid || pr_ready`. The result appears on `pr_*` after that edge. While `pr_valid` is 1 and `pr_ready` is 0, `pr_ctr` and `pr_taken` hold, even if the entry is updated in the meantime.
- R10: Suppose an entry starts at 0 and receives a repeating taken, taken, taken, not-taken pattern, with each update using the counter returned for that branch. From the second repetition onward, exactly three of every four predictions are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_pc | input | PC_W | Program counter of the fetched instruction |
| pr_valid | output | 1 | Prediction result present |
| pr_ready | input | 1 | Consumer takes the prediction result |
| pr_taken | output | 1 | Predicted direction, 1 for taken |
| pr_ctr | output | CTR_W | Counter value read, to be carried to resolve |
| up_branch | input | 1 | Resolving instruction is a branch; enables the write |
| up_index | input | IDX_W | Entry index of the resolving branch |
| up_taken | input | 1 | Actual outcome, 1 for taken |
| up_ctr | input | CTR_W | Counter value carried from prediction time |

## Verification
The assertions assume that `rst` is held long enough for one clock edge. They also assume that `pr_ready` and the lookup inputs change only between edges. They do not assume that `up_ctr` matches the table content, because the block must write back whatever copy it is given. The stimulus drives every input on the falling edge and samples outputs there. It feeds carried values that disagree with the table on purpose. It also places a same-index update in the very cycle of a lookup, and another one while a result is stalled.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } bp_dir_e;

endpackage

// File: rtl/bp_sat_adjust.sv
module bp_sat_adjust
  import bp_pkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             dir,
  output logic [CTR_W-1:0] nxt
);
  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] BOT = '0;

  always_comb begin
    if (bp_dir_e'(dir) == DIR_TAKEN) begin
      nxt = (cur == TOP) ? TOP : cur + 1'b1;
    end else begin
      nxt = (cur == BOT) ? BOT : cur - 1'b1;
    end
  end

  always_comb begin
    assert_sat_high_R1: assert (!(dir && cur == TOP) || nxt == TOP);
    assert_sat_low_R2:  assert (!(!dir && cur == BOT) || nxt == BOT);
    assert_step_R1:     assert (!(dir && cur != TOP) || nxt > cur);
    assert_step_R2:     assert (!(!dir && cur != BOT) || nxt < cur);
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CTR_W-1:0] mem [ENTRIES];

  // Nonblocking read and write in one process: a read of the index being
  // written in the same edge captures the old content.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem[rd_idx];
      if (wr_en) mem[wr_idx] <= wr_data;
    end
  end

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

  assert_read_old_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == $past(mem[rd_idx]));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/bp_handoff.sv
module bp_handoff (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic out_valid,
  input  logic out_ready,
  output logic take
);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  assert_accept_shows_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_stall_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid);
endmodule

// File: rtl/bimodal_predictor.sv
module bimodal_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             pr_valid,
  input  logic             pr_ready,
  output logic             pr_taken,
  output logic [CTR_W-1:0] pr_ctr,
  input  logic             up_branch,
  input  logic [IDX_W-1:0] up_index,
  input  logic             up_taken,
  input  logic [CTR_W-1:0] up_ctr
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic             accept;
  logic [IDX_W-1:0] rd_idx;
  logic [CTR_W-1:0] wr_val;
  logic             unused_pc_bits;

  assign rd_idx         = lk_pc[IDX_HI:IDX_LO];
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0]};

  bp_handoff u_handoff (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .out_valid (pr_valid),
    .out_ready (pr_ready),
    .take      (accept)
  );

  bp_sat_adjust #(.CTR_W(CTR_W)) u_adjust (
    .cur (up_ctr),
    .dir (up_taken),
    .nxt (wr_val)
  );

  bp_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_idx  (rd_idx),
    .rd_data (pr_ctr),
    .wr_en   (up_branch),
    .wr_idx  (up_index),
    .wr_data (wr_val)
  );

  assign pr_taken = pr_ctr[CTR_W-1];

  assert_reset_empties_R7: assert property (@(posedge clk)
    rst |=> !pr_valid);

  assert_result_stable_R9: assert property (@(posedge clk) disable iff (rst)
    pr_valid && !pr_ready |=> $stable(pr_ctr) && $stable(pr_taken));
endmodule

// File: tb/test_bimodal_predictor.sv
module test_bimodal_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int IDX_W = 10;
  localparam int CTR_W = 2;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 0, rst = 1;
  logic lk_valid = 0, lk_ready;
  logic [PC_W-1:0] lk_pc = '0;
  logic pr_valid, pr_ready = 1, pr_taken;
  logic [CTR_W-1:0] pr_ctr;
  logic up_branch = 0, up_taken = 0;
  logic [IDX_W-1:0] up_index = '0;
  logic [CTR_W-1:0] up_ctr = '0;

  int checks = 0, errors = 0;
  int mref [ENTRIES];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) i_bimodal_predictor (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_taken(pr_taken), .pr_ctr(pr_ctr),
    .up_branch(up_branch), .up_index(up_index), .up_taken(up_taken), .up_ctr(up_ctr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int step(input int c, input bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic [PC_W-1:0] pc_of(input int idx);
    return PC_W'(idx) << 2;
  endfunction

  task automatic look(input logic [PC_W-1:0] pcx, output int c, output int t);
    @(negedge clk); lk_valid = 1; lk_pc = pcx;
    @(negedge clk); lk_valid = 0;
    c = pr_ctr; t = pr_taken;
  endtask

  task automatic upd(input int idx, input bit t, input int carried, input bit br);
    @(negedge clk); up_branch = br; up_index = IDX_W'(idx); up_taken = t; up_ctr = CTR_W'(carried);
    @(negedge clk); up_branch = 0;
    if (br) mref[idx] = step(carried, t);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < ENTRIES; i++) mref[i] = 0;
  endtask

  task automatic t_initial;
    chk("R7 pr_valid after reset", pr_valid, 0);
    chk("R9 lk_ready when empty", lk_ready, 1);
  endtask

  task automatic t_sat_up;
    int c, t;
    int exp_seq [5] = '{0, 1, 2, 3, 3};
    for (int k = 0; k < 5; k++) begin
      look(pc_of(5), c, t);
      chk("R1 count up", c, exp_seq[k]);
      chk("R3 taken bit", t, exp_seq[k] >= 2);
      upd(5, 1, c, 1);
    end
  endtask

  task automatic t_sat_down;
    int c, t;
    int exp_seq [5] = '{3, 2, 1, 0, 0};
    for (int k = 0; k < 5; k++) begin
      look(pc_of(5), c, t);
      chk("R2 count down", c, exp_seq[k]);
      chk("R3 taken bit", t, exp_seq[k] >= 2);
      upd(5, 0, c, 1);
    end
  endtask

  task automatic t_carried;
    int c, t;
    upd(9, 1, 2, 1);
    look(pc_of(9), c, t);
    chk("R5 carried 2 taken", c, 3);
    upd(9, 0, 1, 1);
    look(pc_of(9), c, t);
    chk("R5 carried 1 not taken", c, 0);
  endtask

  task automatic t_nobranch;
    int c, t;
    upd(9, 1, 2, 1);
    upd(9, 0, 0, 0);
    look(pc_of(9), c, t);
    chk("R6 no write without branch", c, 3);
  endtask

  task automatic t_alias;
    int c, t;
    upd(17, 1, 1, 1);
    look(pc_of(17) | 32'h3, c, t);
    chk("R4 low bits ignored", c, 2);
    look(pc_of(17) | (32'h1 << (IDX_W + 2)) | 32'h8000_0000, c, t);
    chk("R4 high bits ignored", c, 2);
    look(pc_of(16), c, t);
    chk("R4 neighbour untouched", c, 0);
  endtask

  task automatic t_rbw;
    @(negedge clk);
    lk_valid = 1; lk_pc = pc_of(20);
    up_branch = 1; up_index = 20; up_taken = 1; up_ctr = 0;
    @(negedge clk);
    lk_valid = 0; up_branch = 0;
    mref[20] = 1;
    chk("R8 same cycle old value", pr_ctr, 0);
    begin
      int c, t;
      look(pc_of(20), c, t);
      chk("R8 later sees write", c, 1);
    end
  endtask

  task automatic t_stall;
    upd(40, 1, 0, 1);
    upd(41, 1, 2, 1);
    @(negedge clk); pr_ready = 0; lk_valid = 1; lk_pc = pc_of(40);
    @(negedge clk);
    lk_pc = pc_of(41);
    up_branch = 1; up_index = 40; up_taken = 1; up_ctr = 1;
    chk("R9 valid after accept", pr_valid, 1);
    chk("R9 not ready while stalled", lk_ready, 0);
    chk("R9 first result", pr_ctr, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); up_branch = 0;
      chk("R9 held while stalled", pr_ctr, 1);
      chk("R9 taken held", pr_taken, 0);
    end
    pr_ready = 1;
    @(negedge clk);
    chk("R9 second accepted on drain", pr_ctr, 3);
    chk("R9 second valid", pr_valid, 1);
    lk_valid = 0;
    @(negedge clk);
    chk("R9 empties", pr_valid, 0);
    mref[40] = 2;
  endtask

  task automatic t_loop;
    int c, t, good;
    bit pat [4] = '{1, 1, 1, 0};
    for (int r = 0; r < 4; r++) begin
      good = 0;
      for (int k = 0; k < 4; k++) begin
        look(pc_of(33), c, t);
        chk("R10 model counter", c, mref[33]);
        if (t == pat[k]) good++;
        upd(33, pat[k], c, 1);
      end
      if (r > 0) chk("R10 three of four", good, 3);
    end
  endtask

  task automatic t_reset_clears;
    int c, t, bad;
    do_reset();
    chk("R7 pr_valid cleared", pr_valid, 0);
    bad = 0;
    for (int i = 0; i < ENTRIES; i++) begin
      look(pc_of(i), c, t);
      if (c != 0) bad++;
    end
    chk("R7 entries cleared", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) mref[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_initial();
    t_sat_up();
    t_sat_down();
    t_carried();
    t_nobranch();
    t_alias();
    t_rbw();
    t_stall();
    t_loop();
    t_reset_clears();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule